// File: doc/BRIEF.md
# ATA Task-File Register Bank with Command Sequencer

This block is the device side of a parallel ATA register interface. A host reaches it through an eight-location port. Offsets 2 to 6 are plain byte registers: the sector count, the three address bytes and the device/head byte. Offset 1 is write-only on the feature side, and reads at that offset return the error register. Offset 7 takes command codes on writes and returns status on reads. Offset 0 is the 16-bit data window. The block drives the status byte and a level interrupt toward the host.

Two commands are executed. IDENTIFY DEVICE (0xEC) returns 256 words of identification data through the data window. Those words are computed from parameters, including a space-padded serial-number string and a firmware-revision string. FLUSH CACHE (0xE7) holds the device busy and raises a request level toward the cache logic until a one-cycle completion pulse comes back. Every other code is rejected with an abort indication. Data movement by DMA and the storage medium belong to other blocks.

Top module: `ata_taskfile_unit`

## Requirements
- R1: After reset, status reads 0x40 (only DRDY, bit 6, set), the error register reads 0x00, offsets 2 to 6 read 0x00 and `irq` is low.
- R2: Bytes written at offsets 2 to 6 read back unchanged at the same offsets. A read at offset 1 returns the error register (bit 2 = abort) and never the byte written there.
- R3: A read at offset 7 drops `irq` on the following clock edge. Reads at any other offset leave `irq` unchanged.
- R4: After 0xEC is written to offset 7, `irq` goes high and status reads 0x48 (DRQ bit 3 and DRDY set; BSY bit 7, DF bit 5 and ERR bit 0 clear) before each of the 256 data-word reads. After the 256th word is read, status reads 0x40.
- R5: Identify words 10 to 19 carry the serial string and words 23 to 26 carry the revision string. Each word holds two characters, the earlier character in bits 15:8. Positions past the end of a string read as space (0x20).
- R6: Identify word 85 reads 0x0020 (bit 5 = write cache enabled). Every word outside 10 to 19, 23 to 26 and 85 reads 0x0000.
- R7: After 0xE7 is written, status reads 0xC0 (BSY and DRDY) and `flush_req` is high until a `flush_done` pulse. On the edge that samples the pulse, status becomes 0x40, `flush_req` drops and `irq` rises.
- R8: Any command code other than 0xEC and 0xE7 sets status to 0x41 (ERR and DRDY, no BSY or DRQ), sets the error register to 0x04 (abort) and raises `irq`.
- R9: Writing a command clears ERR and the error register to 0x00.
- R10: While BSY is set, writes to offsets 2 to 6 are ignored, and while BSY or DRQ is set, command writes are ignored.
- R11: A read at offset 0 while DRQ is clear returns 0x0000 and changes neither status nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset 0 to 7 |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 16 | Read data for the current offset (combinational) |
| flush_done | input | 1 | One-cycle completion pulse for a pending flush |
| flush_req | output | 1 | High while a flush is waiting for completion |
| irq | output | 1 | Interrupt request level to the host |

## Verification
The abort path is swept over all 254 command codes the block does not implement. Each code is followed by reads at offsets 1 and 7, so the abort byte, the status value and the way the interrupt clears are tested for every code. The identify transfer is read in full, all 256 words, with status checked before each word, and each word is compared against string characters indexed in the bench. A word-order swap, an off-by-one window or a wrong pad character therefore shows up on a specific word. Register readback uses several address-dependent byte patterns, which separates offset decoding faults from stuck bits. The flush sequence is probed while busy with a register write and a command write, and separately at the completion pulse.

// File: rtl/ata_tf_pkg.sv
// Shared constants for the task-file unit: offsets, status bits, commands,
// identify layout and the sequencer state type.
package ata_tf_pkg;
    localparam int unsigned ADDR_W   = 3;

    // register offsets (host decode depends on these)
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_ERR   = 3'd1;
    localparam logic [2:0] OFS_CMD   = 3'd7;
    localparam int unsigned TF_LO    = 2;
    localparam int unsigned TF_HI    = 6;

    // status bit positions
    localparam int unsigned SB_BSY   = 7;
    localparam int unsigned SB_DRDY  = 6;
    localparam int unsigned SB_DF    = 5;
    localparam int unsigned SB_DRQ   = 3;
    localparam int unsigned SB_ERR   = 0;

    localparam logic [7:0] ERR_ABORT = 8'h04;

    localparam logic [7:0] OP_IDENTIFY = 8'hEC;
    localparam logic [7:0] OP_FLUSH    = 8'hE7;

    // identify data layout
    localparam int unsigned ID_SER_FIRST = 10;
    localparam int unsigned ID_REV_FIRST = 23;
    localparam int unsigned ID_CAP_WORD  = 85;
    localparam logic [15:0] ID_CAP_VALUE = 16'h0020;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PIO   = 2'd1,
        SEQ_FLUSH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ata_tf_regs.sv
// Byte registers at offsets TF_LO..TF_HI (count, address bytes, device).
// Assumes a single access per cycle; writes are dropped while the device is busy.
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    input  logic                     busy,
    output logic [TF_HI:TF_LO][7:0]  regs
);
    localparam int unsigned NREG = TF_HI - TF_LO + 1;

    logic [TF_HI:TF_LO][7:0] regs_q;

    for (genvar g = TF_LO; g <= TF_HI; g++) begin : g_reg
        // hold one task-file byte, loaded on a non-busy write to its offset
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= 8'h00;
            else if (wr && !busy && (addr == ADDR_W'(g)))
                regs_q[g] <= wdata;
        end
    end

    assign regs = regs_q;

    // R10
    busy_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy) |=> $stable(regs_q));

    initial begin
        if (NREG != 5) $display("ata_tf_regs: unexpected register count %0d", NREG);
    end
endmodule

// File: rtl/ata_tf_ident.sv
// Computes identify word `idx` from the serial/revision parameters.
// Assumes strings are packed with the first character in the top byte.
module ata_tf_ident
    import ata_tf_pkg::*;
#(
    parameter int unsigned WORDS        = 256,
    parameter int unsigned SERIAL_CHARS = 20,
    parameter int unsigned REV_CHARS    = 8,
    parameter logic [8*SERIAL_CHARS-1:0] SERIAL_STR = {SERIAL_CHARS{8'h20}},
    parameter logic [8*REV_CHARS-1:0]    REV_STR    = {REV_CHARS{8'h20}}
)(
    input  logic [$clog2(WORDS)-1:0] idx,
    output logic [15:0]              word
);
    localparam int unsigned SER_WORDS = SERIAL_CHARS / 2;
    localparam int unsigned REV_WORDS = REV_CHARS / 2;
    localparam int unsigned SER_BITS  = 8 * SERIAL_CHARS;
    localparam int unsigned REV_BITS  = 8 * REV_CHARS;

    // select the string pair or capability constant for this word
    always_comb begin
        word = 16'h0000;
        for (int k = 0; k < SER_WORDS; k++)
            if (int'(idx) == ID_SER_FIRST + k)
                word = SERIAL_STR[SER_BITS-1-16*k -: 16];
        for (int k = 0; k < REV_WORDS; k++)
            if (int'(idx) == ID_REV_FIRST + k)
                word = REV_STR[REV_BITS-1-16*k -: 16];
        if (int'(idx) == ID_CAP_WORD)
            word = ID_CAP_VALUE;
    end
endmodule

// File: rtl/ata_tf_ctrl.sv
// Command sequencer: decodes commands, runs the identify PIO-in and the
// flush wait, owns the error register, word pointer and interrupt.
// Assumes strobes are already decoded per offset by the top.
module ata_tf_ctrl
    import ata_tf_pkg::*;
#(
    parameter int unsigned WORDS = 256
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic [7:0]               cmd_code,
    input  logic                     data_rd,
    input  logic                     stat_rd,
    input  logic                     flush_done,
    output logic [$clog2(WORDS)-1:0] word_idx,
    output logic [7:0]               status,
    output logic [7:0]               error,
    output logic                     busy,
    output logic                     drq,
    output logic                     flush_req,
    output logic                     irq
);
    localparam int unsigned IDX_W = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             err_q, err_d;
    logic [7:0]       ereg_q, ereg_d;
    logic             irq_q, irq_d;
    logic             raise;

    // next-state decode for commands, word stepping and flush completion
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        err_d   = err_q;
        ereg_d  = ereg_q;
        raise   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: if (cmd_wr) begin
                err_d  = 1'b0;
                ereg_d = 8'h00;
                case (cmd_code)
                    OP_IDENTIFY: begin
                        state_d = SEQ_PIO;
                        idx_d   = '0;
                        raise   = 1'b1;
                    end
                    OP_FLUSH: state_d = SEQ_FLUSH;
                    default: begin
                        err_d  = 1'b1;
                        ereg_d = ERR_ABORT;
                        raise  = 1'b1;
                    end
                endcase
            end
            SEQ_PIO: if (data_rd) begin
                if (idx_q == LAST) state_d = SEQ_IDLE;
                else               idx_d   = idx_q + 1'b1;
            end
            SEQ_FLUSH: if (flush_done) begin
                state_d = SEQ_IDLE;
                raise   = 1'b1;
            end
            default: state_d = SEQ_IDLE;
        endcase
        irq_d = raise | (irq_q & ~stat_rd);
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            err_q   <= 1'b0;
            ereg_q  <= 8'h00;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            err_q   <= err_d;
            ereg_q  <= ereg_d;
            irq_q   <= irq_d;
        end
    end

    // status byte assembly; DRDY is always reported, DF never
    always_comb begin
        status          = 8'h00;
        status[SB_BSY]  = busy;
        status[SB_DRDY] = 1'b1;
        status[SB_DF]   = 1'b0;
        status[SB_DRQ]  = drq;
        status[SB_ERR]  = err_q;
    end

    assign busy      = (state_q == SEQ_FLUSH);
    assign drq       = (state_q == SEQ_PIO);
    assign flush_req = busy;
    assign word_idx  = idx_q;
    assign error     = ereg_q;
    assign irq       = irq_q;

    // R4
    drq_bsy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && drq));
    // R3
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !cmd_wr && !flush_done) |=> !irq);
    // R4
    pio_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && data_rd && word_idx == LAST) |=> (!drq && !busy));
    // R7
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flush_done) |=> (!busy && irq && !flush_req));
    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !drq && cmd_wr && cmd_code != OP_IDENTIFY && cmd_code != OP_FLUSH)
        |=> (status[SB_ERR] && error == ERR_ABORT && irq && !drq && !busy));
    // R9
    cmd_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !drq && cmd_wr && (cmd_code == OP_IDENTIFY || cmd_code == OP_FLUSH))
        |=> (!status[SB_ERR] && error == 8'h00));
endmodule

// File: rtl/ata_taskfile_unit.sv
// Top of the task-file unit: decodes the eight-offset port, ties the register
// bank, command sequencer and identify generator together, muxes read data.
// Assumes at most one of bus_wr/bus_rd per cycle.
module ata_taskfile_unit
    import ata_tf_pkg::*;
#(
    parameter int unsigned IDENT_WORDS  = 256,
    parameter int unsigned SERIAL_CHARS = 20,
    parameter int unsigned REV_CHARS    = 8,
    parameter logic [8*SERIAL_CHARS-1:0] SERIAL_STR = "UNIT-SN-7741        ",
    parameter logic [8*REV_CHARS-1:0]    REV_STR    = "V2.30   "
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              flush_done,
    output logic              flush_req,
    output logic              irq
);
    localparam int unsigned IDX_W = $clog2(IDENT_WORDS);

    logic [TF_HI:TF_LO][7:0] tf_regs;
    logic [IDX_W-1:0]        word_idx;
    logic [15:0]             id_word;
    logic [7:0]              status, error;
    logic                    busy, drq;
    logic                    cmd_wr, data_rd, stat_rd;

    assign cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
    assign data_rd = bus_rd && (bus_addr == OFS_DATA);
    assign stat_rd = bus_rd && (bus_addr == OFS_CMD);

    ata_tf_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .busy  (busy),
        .regs  (tf_regs)
    );

    ata_tf_ctrl #(.WORDS(IDENT_WORDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_code   (bus_wdata),
        .data_rd    (data_rd),
        .stat_rd    (stat_rd),
        .flush_done (flush_done),
        .word_idx   (word_idx),
        .status     (status),
        .error      (error),
        .busy       (busy),
        .drq        (drq),
        .flush_req  (flush_req),
        .irq        (irq)
    );

    ata_tf_ident #(
        .WORDS        (IDENT_WORDS),
        .SERIAL_CHARS (SERIAL_CHARS),
        .REV_CHARS    (REV_CHARS),
        .SERIAL_STR   (SERIAL_STR),
        .REV_STR      (REV_STR)
    ) u_ident (
        .idx  (word_idx),
        .word (id_word)
    );

    // read-data multiplexer by offset
    always_comb begin
        bus_rdata = 16'h0000;
        case (bus_addr)
            OFS_DATA: bus_rdata = drq ? id_word : 16'h0000;
            OFS_ERR:  bus_rdata = {8'h00, error};
            OFS_CMD:  bus_rdata = {8'h00, status};
            default:  bus_rdata = {8'h00, tf_regs[bus_addr]};
        endcase
    end

    // R11
    idle_data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !drq) |=> ($stable(status) && $stable(irq)));
endmodule

// File: tb/ata_taskfile_unit_bench.sv
module ata_taskfile_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [159:0] SER_P = "UNIT-SN-7741        ";
    localparam logic [63:0]  REV_P = "V2.30   ";

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [15:0] bus_rdata;
    logic        flush_done = 1'b0;
    logic        flush_req, irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_unit #(.SERIAL_STR(SER_P), .REV_STR(REV_P)) u_ata_taskfile_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flush_done(flush_done), .flush_req(flush_req), .irq(irq));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] str_ch(input string s, input int n);
        return (n < s.len()) ? s[n] : 8'h20;
    endfunction

    // expected identify word from the string rules
    function automatic logic [15:0] exp_word(input int i);
        string ser = "UNIT-SN-7741";
        string rev = "V2.30";
        if (i >= 10 && i <= 19) return {str_ch(ser, 2*(i-10)), str_ch(ser, 2*(i-10)+1)};
        if (i >= 23 && i <= 26) return {str_ch(rev, 2*(i-23)), str_ch(rev, 2*(i-23)+1)};
        if (i == 85) return 16'h0020;
        return 16'h0000;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(3'd7, v); chk("R1 status", v, 16'h0040);
        rd(3'd1, v); chk("R1 error", v, 16'h0000);
        for (int a = 2; a <= 6; a++) begin rd(3'(a), v); chk("R1 reg", v, 16'h0000); end
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R2 readback patterns
        for (int p = 0; p < 4; p++) begin
            for (int a = 1; a <= 6; a++) wr(3'(a), 8'((a*37 + p*91 + 5) & 8'hFF));
            for (int a = 2; a <= 6; a++) begin
                rd(3'(a), v); chk("R2 readback", v, {8'h00, 8'((a*37 + p*91 + 5) & 8'hFF)});
            end
            rd(3'd1, v); chk("R2 offset1 is error", v, 16'h0000);
        end

        // R11 idle data read
        rd(3'd0, v); chk("R11 data idle", v, 16'h0000);
        rd(3'd7, v); chk("R11 status unchanged", v, 16'h0040);
        chk("R11 irq unchanged", {15'd0, irq}, 16'h0000);

        // R8 / R3 / R9 sweep of unimplemented codes
        for (int c = 0; c < 256; c++) begin
            if (c == 8'hEC || c == 8'hE7) continue;
            wr(3'd7, 8'(c));
            chk("R8 irq raised", {15'd0, irq}, 16'h0001);
            rd(3'd1, v); chk("R8 abort byte", v, 16'h0004);
            chk("R3 error read keeps irq", {15'd0, irq}, 16'h0001);
            rd(3'd7, v); chk("R8 status", v, 16'h0041);
            chk("R3 status read clears irq", {15'd0, irq}, 16'h0000);
        end

        // R4 / R5 / R6 identify, with R9 clearing the previous error
        wr(3'd7, 8'hEC);
        chk("R4 irq before block", {15'd0, irq}, 16'h0001);
        rd(3'd1, v); chk("R9 error cleared", v, 16'h0000);
        for (int i = 0; i < 256; i++) begin
            rd(3'd7, v); chk("R4 status per word", v, 16'h0048);
            if (i == 100) begin
                wr(3'd7, 8'hE7);
                chk("R10 command ignored in DRQ", {15'd0, flush_req}, 16'h0000);
            end
            rd(3'd0, v);
            if ((i >= 10 && i <= 19) || (i >= 23 && i <= 26)) chk("R5 string word", v, exp_word(i));
            else chk("R6 other word", v, exp_word(i));
        end
        rd(3'd7, v); chk("R4 status after last", v, 16'h0040);
        rd(3'd0, v); chk("R11 data after end", v, 16'h0000);

        // R7 / R10 flush
        wr(3'd3, 8'h11);
        wr(3'd7, 8'hE7);
        rd(3'd7, v); chk("R7 status busy", v, 16'h00C0);
        chk("R7 flush_req", {15'd0, flush_req}, 16'h0001);
        chk("R7 irq low while busy", {15'd0, irq}, 16'h0000);
        wr(3'd3, 8'h5A);
        rd(3'd3, v); chk("R10 reg write ignored", v, 16'h0011);
        wr(3'd7, 8'hEC);
        rd(3'd7, v); chk("R10 command ignored in BSY", v, 16'h00C0);
        repeat (5) @(posedge clk);
        rd(3'd7, v); chk("R7 still busy", v, 16'h00C0);
        @(negedge clk) flush_done = 1'b1;
        @(posedge clk); #1 flush_done = 1'b0;
        chk("R7 irq on completion", {15'd0, irq}, 16'h0001);
        chk("R7 flush_req drop", {15'd0, flush_req}, 16'h0000);
        rd(3'd7, v); chk("R7 status done", v, 16'h0040);
        chk("R3 irq cleared", {15'd0, irq}, 16'h0000);
        wr(3'd3, 8'h5A);
        rd(3'd3, v); chk("R2 write after busy", v, 16'h005A);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule